// File: doc/BRIEF.md
# Receive Interrupt Source Controller

This block gathers the event sources on the receive side of a serial radio interface and merges them into a single interrupt request. Three events can be watched: a strobe saying the start of a message was found, a received byte being stored in a small receive FIFO, and that FIFO reaching its capacity of four bytes. Each source has its own sticky memory flag and its own enable bit. The interrupt line is the OR of every flag whose enable bit is set.

The receive FIFO is part of the block. A deserializer upstream hands it bytes through a one-cycle valid strobe. Software drains the FIFO through a read-pop port and can empty it with a clear input. Software can take an interrupt on every byte and fetch one byte at a time. It can instead wait for the full event and fetch four bytes in one burst. A two-entry register port exposes the enable mask and the flags. Flags are cleared by writing 1 to their bit.

Top module: `rx_irq_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the enable mask and all flags are 0, irq_o is low and the FIFO is empty with fifo_cnt_o = 0.
- R2: Register address 0 holds the enable mask: bit 0 enables the start-detect source, bit 1 the new-byte source and bit 2 the FIFO-full source. The mask reads back from address 0, and bits 7..3 read as 0.
- R3: Register address 1 reads the memory flags, using the same bit positions as R2. A flag sets on the clock edge after its event, whatever the state of its enable bit.
- R4: Writing address 1 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. If an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: irq_o is high exactly while at least one flag is set together with its enable bit. Any combination of enable bits may be set at once.
- R6: A byte is accepted on byte_vld_i only when the FIFO holds fewer than 4 bytes. Each accepted byte raises the new-byte event. A byte offered while the FIFO is full is dropped and raises no event.
- R7: The FIFO-full event fires once, on the accepted write that raises the occupancy from 3 to 4. It does not fire again while the FIFO stays full, and it does not fire when a push and a pop at occupancy 3 happen together.
- R8: The FIFO is first-in first-out. rd_data_o shows the oldest byte, and cpu_rd_i removes it. A read while the FIFO is empty changes nothing.
- R9: fifo_clr_i empties the FIFO and sets the occupancy to 0 at the next edge. It takes priority over a push in the same cycle, and the discarded byte raises no new-byte event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_det_i | input | 1 | One-cycle strobe: message start found |
| byte_vld_i | input | 1 | One-cycle strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received byte from the deserializer |
| fifo_clr_i | input | 1 | Empty the receive FIFO |
| cpu_rd_i | input | 1 | Pop the oldest FIFO byte |
| rd_data_o | output | 8 | Oldest byte in the FIFO |
| fifo_cnt_o | output | 3 | FIFO occupancy, 0 to 4 |
| fifo_empty_o | output | 1 | FIFO holds no byte |
| fifo_full_o | output | 1 | FIFO holds 4 bytes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 enable mask, 1 flags |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_o | output | 1 | Combined receive interrupt |

## Verification
The assertions check the following on every cycle:
- An enabled event raises irq_o on the next edge.
- A set flag with no clearing write stays set.
- An event wins over a same-cycle clear.
- The occupancy never exceeds four.
- A clear empties the FIFO, and a full FIFO stays full unless it is read or cleared.
- A write to the enable mask lands.

Some behaviours only the directed scenarios can show: the order of the bytes read out, that a byte offered to a full FIFO is dropped, that the full event fires only once per fill, and that a push together with a pop at occupancy three raises no full event. The same holds for the combined effect of several enable bits on irq_o.

// File: rtl/rxi_pkg.sv
// Package: shared constants and types for the receive interrupt controller.
// Assumes three event sources in fixed bit order (start, byte, full).
package rxi_pkg;
    localparam int SRC_N     = 3;
    localparam int SRC_START = 0;
    localparam int SRC_BYTE  = 1;
    localparam int SRC_FULL  = 2;

    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_FLAGS  = 1'b1
    } rxi_reg_e;
endpackage

// File: rtl/rxi_fifo.sv
// Module: rxi_fifo
// Small circular receive FIFO with show-ahead read data. It produces
// single-cycle events for "byte accepted" and "occupancy reached DEPTH".
// Assumes: clear has priority over push and pop; a push into a full FIFO is
// dropped; a pop from an empty FIFO is ignored.
module rxi_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              byte_evt_o,
    output logic              full_evt_o
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  count_nxt;
    logic              do_push;
    logic              do_pop;

    // Advance a pointer with wrap at DEPTH-1 (works for any depth).
    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (count == '0);
    assign full_o  = (count == CNT_W'(DEPTH));
    assign count_o = count;

    // Qualify the requests: clear overrides, full blocks push, empty blocks pop.
    always_comb begin
        do_push = push_i && !full_o && !clr_i;
        do_pop  = pop_i && !empty_o && !clr_i;
    end

    // Next occupancy from the qualified push and pop.
    always_comb begin
        unique case ({do_push, do_pop})
            2'b10:   count_nxt = count + 1'b1;
            2'b01:   count_nxt = count - 1'b1;
            default: count_nxt = count;
        endcase
    end

    // Events go to the flag logic; full fires only on the transition to DEPTH.
    always_comb begin
        byte_evt_o = do_push;
        full_evt_o = do_push && (count_nxt == CNT_W'(DEPTH)) && !full_o;
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            count <= count_nxt;
        end
    end

    // Data storage, written only on accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= data_i;
    end

    assign rd_data_o = store[rd_ptr];

    // R6: the occupancy never exceeds the depth.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R9: a clear empties the FIFO at the next edge.
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));

    // R7: the full event leads to a full FIFO.
    assert_full_event_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full_evt_o |=> full_o);

    // R6: a full FIFO with no read and no clear stays full (extra byte dropped).
    assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !pop_i && !clr_i) |=> full_o);
endmodule

// File: rtl/rxi_flags.sv
// Module: rxi_flags
// One sticky memory flag per event source, cleared by write-1. It merges the
// enabled flags onto one interrupt line.
// Assumes: event and clear vectors are single-cycle; set beats clear.
module rxi_flags #(
    parameter int SRC_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt_i,
    input  logic [SRC_N-1:0] clr_i,
    input  logic [SRC_N-1:0] en_i,
    output logic [SRC_N-1:0] flags_o,
    output logic             irq_o
);
    logic [SRC_N-1:0] flag_q;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        // Sticky flag for source i: set on event, otherwise clear on write-1.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[i] <= 1'b0;
            else if (evt_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
        end

        // R5: an enabled event raises the interrupt on the next edge.
        assert_enabled_event_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && en_i[i]) |=> irq_o);

        // R4: an event wins over a same-cycle clear.
        assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && clr_i[i]) |=> flags_o[i]);

        // R3: a set flag without a clear stays set.
        assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
    end

    assign flags_o = flag_q;

    // Combine the enabled flags onto the single request line.
    always_comb irq_o = |(flag_q & en_i);
endmodule

// File: rtl/rxi_regs.sv
// Module: rxi_regs
// Register port: the enable mask at one address and the flags at the other.
// Writes to the flags address become a write-1-to-clear vector.
// Assumes: reads are combinational and have no side effects.
module rxi_regs
    import rxi_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int SRC_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [SRC_N-1:0] flags_i,
    output logic [SRC_N-1:0] en_o,
    output logic [SRC_N-1:0] clr_o,
    output logic [REG_W-1:0] rdata_o
);
    rxi_reg_e         sel;
    logic [SRC_N-1:0] en_q;

    assign sel = rxi_reg_e'(addr_i);

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                         en_q <= '0;
        else if (wr_i && sel == REG_ENABLE) en_q <= wdata_i[SRC_N-1:0];
    end

    // Write-1-to-clear request toward the flag bank.
    always_comb clr_o = (wr_i && sel == REG_FLAGS) ? wdata_i[SRC_N-1:0] : '0;

    // Read multiplexer; unused upper bits read as zero.
    always_comb begin
        rdata_o = '0;
        unique case (sel)
            REG_ENABLE: rdata_o[SRC_N-1:0] = en_q;
            REG_FLAGS:  rdata_o[SRC_N-1:0] = flags_i;
            default:    rdata_o = '0;
        endcase
    end

    assign en_o = en_q;

    // R2: a write to the enable address lands in the mask.
    assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == REG_ENABLE) |=> (en_o == $past(wdata_i[SRC_N-1:0])));
endmodule

// File: rtl/rx_irq_ctrl.sv
// Module: rx_irq_ctrl (top)
// Receive interrupt source controller. It contains the receive FIFO, the
// register port and the sticky flag bank. The start-detect strobe, the
// byte-accepted event and the FIFO-full event feed the flags.
// Assumes: strobes are synchronous to clk and last one cycle.
module rx_irq_ctrl
    import rxi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int REG_W  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              fifo_clr_i,
    input  logic              cpu_rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  fifo_cnt_o,
    output logic              fifo_empty_o,
    output logic              fifo_full_o,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    logic [SRC_N-1:0] evt;
    logic [SRC_N-1:0] clr;
    logic [SRC_N-1:0] en;
    logic [SRC_N-1:0] flags;
    logic             byte_evt;
    logic             full_evt;

    rxi_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (byte_vld_i),
        .data_i     (byte_i),
        .pop_i      (cpu_rd_i),
        .clr_i      (fifo_clr_i),
        .rd_data_o  (rd_data_o),
        .count_o    (fifo_cnt_o),
        .empty_o    (fifo_empty_o),
        .full_o     (fifo_full_o),
        .byte_evt_o (byte_evt),
        .full_evt_o (full_evt)
    );

    // Gather the event vector in the bit order of the register map.
    always_comb begin
        evt            = '0;
        evt[SRC_START] = start_det_i;
        evt[SRC_BYTE]  = byte_evt;
        evt[SRC_FULL]  = full_evt;
    end

    rxi_regs #(.REG_W(REG_W), .SRC_N(SRC_N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .flags_i (flags),
        .en_o    (en),
        .clr_o   (clr),
        .rdata_o (reg_rdata_o)
    );

    rxi_flags #(.SRC_N(SRC_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .clr_i   (clr),
        .en_i    (en),
        .flags_o (flags),
        .irq_o   (irq_o)
    );

    // R1: the interrupt line is low on the first cycle out of reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && fifo_empty_o));
endmodule

// File: tb/tb_rx_irq_ctrl.sv
module tb_rx_irq_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_det_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       fifo_clr_i = 1'b0;
    logic       cpu_rd_i = 1'b0;
    logic [7:0] rd_data_o;
    logic [2:0] fifo_cnt_o;
    logic       fifo_empty_o;
    logic       fifo_full_o;
    logic       reg_wr_i = 1'b0;
    logic       reg_addr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rx_irq_ctrl dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        cyc();
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] v);
        reg_addr_i = a; #1; v = reg_rdata_o;
    endtask

    task automatic push(input logic [7:0] d);
        byte_vld_i = 1'b1; byte_i = d;
        cyc();
        byte_vld_i = 1'b0;
    endtask

    task automatic pop();
        cpu_rd_i = 1'b1; cyc(); cpu_rd_i = 1'b0;
    endtask

    task automatic start_pulse();
        start_det_i = 1'b1; cyc(); start_det_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 irq", irq_o, 0);
        chk("R1 count", fifo_cnt_o, 0);
        chk("R1 empty", fifo_empty_o, 1);
        rd_reg(1'b0, v); chk("R1 enable", v, 0);
        rd_reg(1'b1, v); chk("R1 flags", v, 0);
    endtask

    task automatic t_enable_rw();
        logic [7:0] v;
        wr_reg(1'b0, 8'hFF);
        rd_reg(1'b0, v); chk("R2 mask readback", v, 8'h07);
        wr_reg(1'b0, 8'h05);
        rd_reg(1'b0, v); chk("R2 mask 101", v, 8'h05);
        wr_reg(1'b0, 8'h00);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        start_pulse();
        rd_reg(1'b1, v); chk("R3 start flag without enable", v, 8'h01);
        chk("R5 irq off when disabled", irq_o, 0);
        wr_reg(1'b1, 8'h00);
        rd_reg(1'b1, v); chk("R4 write 0 keeps flag", v, 8'h01);
        wr_reg(1'b0, 8'h01);
        chk("R5 enabling pending flag raises irq", irq_o, 1);
        wr_reg(1'b1, 8'h01);
        rd_reg(1'b1, v); chk("R4 write 1 clears flag", v, 8'h00);
        chk("R5 irq drops after clear", irq_o, 0);
        // event and clearing write in the same cycle
        start_det_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 1'b1; reg_wdata_i = 8'h01;
        cyc();
        start_det_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        rd_reg(1'b1, v); chk("R4 set wins over clear", v, 8'h01);
        chk("R5 irq after set-wins", irq_o, 1);
        wr_reg(1'b1, 8'h07);
        wr_reg(1'b0, 8'h00);
    endtask

    task automatic t_fifo_fill();
        logic [7:0] v;
        wr_reg(1'b0, 8'h02);
        push(8'hA5);
        chk("R6 count after one push", fifo_cnt_o, 1);
        rd_reg(1'b1, v); chk("R6 byte flag", v, 8'h02);
        chk("R5 byte irq", irq_o, 1);
        chk("R8 head byte", rd_data_o, 8'hA5);
        push(8'h3C); push(8'h7E);
        rd_reg(1'b1, v); chk("R7 no full flag at 3", v, 8'h02);
        push(8'hF0);
        chk("R7 count four", fifo_cnt_o, 4);
        chk("R7 full out", fifo_full_o, 1);
        rd_reg(1'b1, v); chk("R7 full flag set", v, 8'h06);
        wr_reg(1'b1, 8'h06);
        push(8'h11);
        chk("R6 dropped push keeps count", fifo_cnt_o, 4);
        rd_reg(1'b1, v); chk("R6 dropped push no event", v, 8'h00);
        cyc(); cyc(); cyc();
        rd_reg(1'b1, v); chk("R7 full fires once", v, 8'h00);
        chk("R8 first out", rd_data_o, 8'hA5); pop();
        chk("R8 second out", rd_data_o, 8'h3C); pop();
        chk("R8 third out", rd_data_o, 8'h7E); pop();
        chk("R8 fourth out", rd_data_o, 8'hF0); pop();
        chk("R8 empty after four reads", fifo_empty_o, 1);
        pop();
        chk("R8 read on empty ignored", fifo_cnt_o, 0);
        wr_reg(1'b0, 8'h00);
    endtask

    task automatic t_push_pop_and_clear();
        logic [7:0] v;
        push(8'h01); push(8'h02); push(8'h03);
        wr_reg(1'b1, 8'h07);
        byte_vld_i = 1'b1; byte_i = 8'h04; cpu_rd_i = 1'b1;
        cyc();
        byte_vld_i = 1'b0; cpu_rd_i = 1'b0;
        chk("R7 push+pop at 3 keeps 3", fifo_cnt_o, 3);
        rd_reg(1'b1, v); chk("R7 push+pop no full flag", v, 8'h02);
        chk("R8 head after push+pop", rd_data_o, 8'h02);
        fifo_clr_i = 1'b1; cyc(); fifo_clr_i = 1'b0;
        chk("R9 clear empties", fifo_cnt_o, 0);
        chk("R9 empty flag", fifo_empty_o, 1);
        wr_reg(1'b1, 8'h07);
        fifo_clr_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'h99;
        cyc();
        fifo_clr_i = 1'b0; byte_vld_i = 1'b0;
        chk("R9 clear beats push", fifo_cnt_o, 0);
        rd_reg(1'b1, v); chk("R9 no byte event on cleared push", v, 8'h00);
    endtask

    task automatic t_multi_enable();
        logic [7:0] v;
        wr_reg(1'b0, 8'h05);
        push(8'h55);
        rd_reg(1'b1, v); chk("R3 byte flag while disabled", v, 8'h02);
        chk("R5 disabled byte flag no irq", irq_o, 0);
        start_pulse();
        chk("R5 start raises irq with two enables", irq_o, 1);
        wr_reg(1'b1, 8'h01);
        chk("R5 irq low with only disabled flag left", irq_o, 0);
        push(8'h66); push(8'h77); push(8'h88);
        chk("R5 full source raises irq", irq_o, 1);
        wr_reg(1'b1, 8'h04);
        chk("R4 clear full flag drops irq", irq_o, 0);
        rd_reg(1'b1, v); chk("R4 other flag kept", v, 8'h02);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_enable_rw();
        t_flags();
        t_fifo_fill();
        t_push_pop_and_clear();
        t_multi_enable();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule